// File: doc/BRIEF.md
# Subroutine Return Address Predictor

This block keeps a small last-in first-out store of return addresses for the fetch stage. When fetch meets a call, the block records the address of the instruction that follows the call, which is the call address plus the fixed instruction size. When fetch meets an instruction whose predecode return bit is set, the block supplies the most recent recorded address as the predicted next fetch address and discards it.

The predicted address and its valid flag always show the current top entry. A consumer samples them in the cycle it asserts the return input, so the prediction for a return is ready without waiting a clock. A call and a return in the same cycle replace the top entry and leave the depth unchanged.

The store holds a fixed number of entries. A compile-time switch selects what a call does when the store is full. In circular mode the call overwrites the oldest entry. In hold mode the call is dropped and the contents stay as they were.

Top module: `ret_addr_stack`

## Requirements
- R1: After reset, `pred_valid_o` is 0.
- R2: A call alone (call_i=1, ret_i=0) on a store that is not full makes the next top entry equal to call_pc_i + 4, computed modulo 2^32, with `pred_valid_o` = 1, and raises the depth by one.
- R3: A return alone (ret_i=1, call_i=0) on a non-empty store removes the top entry, so the entry pushed before it becomes the output. When the depth falls to 0, `pred_valid_o` is 0.
- R4: A return alone on an empty store changes nothing, and `pred_valid_o` stays 0.
- R5: A call and a return in the same cycle on a non-empty store replace the top entry with call_pc_i + 4 and keep the depth. On an empty store the pair acts as a call alone.
- R6: With WRAP_ON_FULL=1, a call alone on a full store writes call_pc_i + 4 as the new top and drops the oldest entry. The store stays full, so only the four newest addresses can be returned before the store reads empty.
- R7: With WRAP_ON_FULL=0, a call alone on a full store is ignored. The output address and the depth do not change.
- R8: The store holds four entries. Four calls followed by four returns yield the four addresses in reverse order.
- R9: The return address wraps modulo 2^32, so a call at 0xFFFFFFFC records 0x00000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| call_i | input | 1 | A call is being fetched this cycle |
| call_pc_i | input | 32 | Address of the call instruction |
| ret_i | input | 1 | Predecode return bit of the instruction being fetched |
| pred_addr_o | output | 32 | Predicted return address (current top entry) |
| pred_valid_o | output | 1 | The store holds at least one entry |

## Verification
The assertions assume that `call_i` and `ret_i` are held low while reset is active. They also assume that `call_pc_i` is stable around the clock edge whenever `call_i` is high, because they compare the new top with the address captured a cycle earlier. The bench drives all inputs on the falling edge and keeps them at zero across every reset. It then walks every sequence of six operations drawn from idle, call, return, and call with return, on one instance of each overflow mode. This reaches the full and empty boundaries from every path.

// File: rtl/ret_addr_stack.sv
module ret_addr_stack #(
  parameter int AW           = 32,
  parameter int DEPTH        = 4,
  parameter int INST_BYTES   = 4,
  parameter bit WRAP_ON_FULL = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          call_i,
  input  logic [AW-1:0] call_pc_i,
  input  logic          ret_i,
  output logic [AW-1:0] pred_addr_o,
  output logic          pred_valid_o
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [AW-1:0] slot [DEPTH];
  logic [PW-1:0] wr_ptr;
  logic [CW-1:0] fill;

  wire          full     = (fill == CW'(DEPTH));
  wire          empty    = (fill == '0);
  wire [AW-1:0] ret_addr = call_pc_i + AW'(INST_BYTES);
  wire [PW-1:0] nxt_ptr  = (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
  wire [PW-1:0] top_ptr  = (wr_ptr == '0) ? LAST : wr_ptr - 1'b1;

  wire do_swap = call_i & ret_i & ~empty;
  wire do_push = call_i & ~do_swap & (~full | WRAP_ON_FULL);
  wire do_pop  = ret_i & ~call_i & ~empty;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      fill   <= '0;
    end else if (do_push) begin
      wr_ptr <= nxt_ptr;
      if (!full) fill <= fill + 1'b1;
    end else if (do_pop) begin
      wr_ptr <= top_ptr;
      fill   <= fill - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && do_push) slot[wr_ptr] <= ret_addr;
    else if (rst_n && do_swap) slot[top_ptr] <= ret_addr;
  end

  assign pred_addr_o  = slot[top_ptr];
  assign pred_valid_o = ~empty;

  // R2
  push_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (call_i && !ret_i && !full) |=> (pred_valid_o && pred_addr_o == $past(ret_addr)));

  // R3
  pop_shrinks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_i && !call_i && !empty) |=> (fill == CW'($past(fill) - 1'b1)));

  // R4
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_i && !call_i && empty) |=> !pred_valid_o);

  // R5
  swap_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (call_i && ret_i && !empty) |=> (fill == $past(fill) && pred_addr_o == $past(ret_addr)));

  generate
    if (WRAP_ON_FULL) begin : g_wrap
      // R6
      wrap_over_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (call_i && !ret_i && full) |=> (full && pred_addr_o == $past(ret_addr)));
    end else begin : g_hold
      // R7
      hold_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (call_i && !ret_i && full) |=> (full && $stable(pred_addr_o)));
    end
  endgenerate

endmodule

// File: tb/test_ret_addr_stack.sv
module test_ret_addr_stack;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic call_i = 1'b0;
  logic ret_i = 1'b0;
  logic [31:0] call_pc_i = '0;
  logic [31:0] addr_w, addr_h;
  logic valid_w, valid_h;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] m [2][4];
  int cnt [2];

  always #10 clk = ~clk;

  ret_addr_stack #(.WRAP_ON_FULL(1'b1)) i_ret_addr_stack (
    .clk(clk), .rst_n(rst_n), .call_i(call_i), .call_pc_i(call_pc_i),
    .ret_i(ret_i), .pred_addr_o(addr_w), .pred_valid_o(valid_w));

  ret_addr_stack #(.WRAP_ON_FULL(1'b0)) i_ret_addr_stack_hold (
    .clk(clk), .rst_n(rst_n), .call_i(call_i), .call_pc_i(call_pc_i),
    .ret_i(ret_i), .pred_addr_o(addr_h), .pred_valid_o(valid_h));

  task automatic check(input string tag, input int md);
    logic gv, ev;
    logic [31:0] ga, ea;
    gv = md == 0 ? valid_w : valid_h;
    ga = md == 0 ? addr_w : addr_h;
    ev = cnt[md] > 0;
    ea = ev ? m[md][cnt[md]-1] : '0;
    checks++;
    if (gv !== ev || (ev && ga !== ea)) begin
      errors++;
      $display("FAIL %s mode=%0d: valid=%0b addr=%h, expected valid=%0b addr=%h",
               tag, md, gv, ga, ev, ea);
    end
  endtask

  task automatic do_reset();
    call_i = 0; ret_i = 0; rst_n = 0;
    @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    cnt[0] = 0; cnt[1] = 0;
    check("R1", 0);
    check("R1", 1);
  endtask

  task automatic step(input bit ps, input bit pp, input logic [31:0] pc, input string forced);
    string tag [2];
    call_i = ps; ret_i = pp; call_pc_i = pc;
    for (int md = 0; md < 2; md++) begin
      if (ps && pp && cnt[md] > 0) tag[md] = "R5";
      else if (ps && cnt[md] == 4) tag[md] = md == 0 ? "R6" : "R7";
      else if (ps) tag[md] = "R2";
      else if (pp && cnt[md] == 0) tag[md] = "R4";
      else tag[md] = "R3";
      if (forced != "") tag[md] = forced;
    end
    @(posedge clk);
    for (int md = 0; md < 2; md++) begin
      if (ps && pp && cnt[md] > 0) m[md][cnt[md]-1] = pc + 32'd4;
      else if (ps) begin
        if (cnt[md] < 4) begin
          m[md][cnt[md]] = pc + 32'd4;
          cnt[md]++;
        end else if (md == 0) begin
          for (int k = 0; k < 3; k++) m[md][k] = m[md][k+1];
          m[md][3] = pc + 32'd4;
        end
      end else if (pp && cnt[md] > 0) cnt[md]--;
    end
    @(negedge clk);
    call_i = 0; ret_i = 0;
    check(tag[0], 0);
    check(tag[1], 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: expired, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R8: fill four entries, drain in reverse
    for (int k = 0; k < 4; k++) step(1, 0, 32'h0000_FC34 + 32'(k * 256), "R8");
    for (int k = 0; k < 4; k++) step(0, 1, 32'h0, "R8");
    // R9: address wraps past the top of the space
    step(1, 0, 32'hFFFF_FFFC, "R9");
    step(0, 1, 32'h0, "R3");
    step(0, 1, 32'h0, "R4");
    // R6, R7: overflow with five distinct calls then drain
    for (int k = 0; k < 5; k++) step(1, 0, 32'h0000_1000 + 32'(k * 16), "");
    for (int k = 0; k < 5; k++) step(0, 1, 32'h0, "");
    // sweep every 6-operation sequence over idle/call/return/both
    for (int s = 0; s < 4096; s++) begin
      do_reset();
      for (int k = 0; k < 6; k++) begin
        int op;
        op = (s >> (2 * k)) & 3;
        step(op[0], op[1], 32'h0000_4000 + 32'(s * 64) + 32'(k * 8), "");
      end
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule